// File: doc/BRIEF.md
# Hiccup-Mode Overload Guard

This block decides, for one supply channel, how the output stage reacts when an external current-limit comparator reports an overload. Two modes exist. In the timed mode the channel is switched off for a long interval and then brought back for a short retry window, during which the current stays clamped. The off/retry cycle repeats until one whole retry window passes with no overload, and only then does the channel return to normal running. In the clamp mode the output stays on at all times, and the overload flag simply tracks the comparator.

All timing comes from a one-millisecond tick input. The off interval and the retry window are parameters counted in ticks, with defaults of 900 and 20. A limit-select output follows the high/low current-limit choice in every enabled state, including the retry window. Overloads are ignored while the channel's soft start is still running, and the flag stays low during that time. Dropping the channel enable returns the block to idle on the next clock.

Top module: `olp_guard`

## Requirements
- R1: After reset, out_en is 0 and ovl_flag is 0.
- R2: When ch_en is 0 at a clock edge, from any state, out_en and ovl_flag are both 0 after that edge.
- R3: While ch_en is 1 and ss_done is 0, out_en is 1, the ovl input is ignored and ovl_flag stays 0.
- R4: In normal running with clamp_mode = 0, ovl = 1 turns out_en off and sets ovl_flag on the next clock.
- R5: The off interval lasts exactly T_OFF_MS ticks. On the tick that ends it, out_en returns to 1 and ovl_flag stays 1 (retry window).
- R6: If ovl is 1 in any cycle of the retry window, the window ends after T_ON_MS ticks and a new off interval begins (out_en 0, ovl_flag 1).
- R7: A retry window of T_ON_MS ticks with no overload returns the channel to normal running, with out_en 1 and ovl_flag 0.
- R8: With clamp_mode = 1 in normal running, out_en stays 1, and ovl_flag equals the ovl value sampled at the previous clock edge.
- R9: Setting clamp_mode to 1 during an off interval or a retry window aborts the cycle on the next clock: out_en becomes 1 and ovl_flag follows ovl.
- R10: lim_hi equals hi_limit (1 = higher current limit, 0 = lower) at all times, including during the retry window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | 1 | Channel enable |
| clamp_mode | input | 1 | 1 = clamp mode, 0 = timed off/retry mode |
| hi_limit | input | 1 | Current-limit select: 1 = high limit, 0 = low limit |
| ss_done | input | 1 | Soft start of the channel has finished |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| ovl | input | 1 | Current-limit comparator output |
| out_en | output | 1 | Output stage enable |
| lim_hi | output | 1 | Current-limit select passed to the output stage |
| ovl_flag | output | 1 | Overload flag |

## Verification
The bench builds the block with T_OFF_MS = 5 and T_ON_MS = 3. With these values the tick before the end of an off interval, the tick that ends it, and a complete retry window that fails or passes can each be reached in a few tick pulses. The bench drives the tick pulses itself, so each interval boundary falls on a known cycle. This lets it check one tick short of expiry and exactly at expiry, and also abort a cycle partway through by setting clamp mode or by dropping the channel enable.

// File: rtl/olp_pkg.sv
package olp_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_SOFT  = 3'd1,
    S_RUN   = 3'd2,
    S_OFF   = 3'd3,
    S_RETRY = 3'd4
  } olp_state_e;

  // Output stage is driven in every enabled state except the off interval.
  function automatic logic olp_out_on(olp_state_e st);
    return (st == S_SOFT) || (st == S_RUN) || (st == S_RETRY);
  endfunction

  // Flag value that goes with the state being entered.
  function automatic logic olp_flag_for(olp_state_e nxt, logic clamp, logic ovl);
    case (nxt)
      S_OFF, S_RETRY: return 1'b1;
      S_RUN:          return clamp & ovl;
      default:        return 1'b0;
    endcase
  endfunction

  // Bits needed to count up to n-1.
  function automatic int olp_cnt_bits(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/olp_interval_timer.sv
module olp_interval_timer #(
  parameter int T_OFF_MS = 900,
  parameter int T_ON_MS  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic sel_off,
  input  logic clr,
  input  logic tick,
  output logic expired
);
  import olp_pkg::*;

  localparam int TMAX = (T_OFF_MS > T_ON_MS) ? T_OFF_MS : T_ON_MS;
  localparam int CW   = olp_cnt_bits(TMAX);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit_m1;

  assign limit_m1 = sel_off ? CW'(T_OFF_MS - 1) : CW'(T_ON_MS - 1);
  assign expired  = active && tick && (cnt == limit_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr || !active)   cnt <= '0;
    else if (tick && !expired) cnt <= cnt + 1'b1;
  end

  // R5/R6: the count never runs past the selected interval
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= limit_m1));

endmodule

// File: rtl/olp_hiccup_fsm.sv
module olp_hiccup_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic ch_en,
  input  logic clamp_mode,
  input  logic ss_done,
  input  logic ovl,
  input  logic interval_done,
  output olp_pkg::olp_state_e st_q,
  output logic state_change,
  output logic out_en,
  output logic ovl_flag
);
  import olp_pkg::*;

  olp_state_e st_d;
  logic       seen_q;
  logic       retry_fail;

  assign retry_fail = seen_q | ovl;

  always_comb begin
    st_d = st_q;
    if (!ch_en) st_d = S_IDLE;
    else begin
      case (st_q)
        S_IDLE, S_SOFT: st_d = ss_done ? S_RUN : S_SOFT;
        S_RUN:          st_d = (!clamp_mode && ovl) ? S_OFF : S_RUN;
        S_OFF:          st_d = clamp_mode ? S_RUN :
                               (interval_done ? S_RETRY : S_OFF);
        S_RETRY:        st_d = clamp_mode ? S_RUN :
                               (interval_done ? (retry_fail ? S_OFF : S_RUN) : S_RETRY);
        default:        st_d = S_IDLE;
      endcase
    end
  end

  assign state_change = (st_d != st_q);
  assign out_en       = olp_out_on(st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      ovl_flag <= 1'b0;
      seen_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      ovl_flag <= olp_flag_for(st_d, clamp_mode, ovl);
      seen_q   <= (st_q == S_RETRY) && (st_d == S_RETRY) && retry_fail;
    end
  end

  p_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |=> (!out_en && !ovl_flag));

  p_soft_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SOFT) |-> (out_en && !ovl_flag));

  p_dyn_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN && ch_en && !clamp_mode && ovl) |=> (!out_en && ovl_flag));

  p_retry_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_OFF && interval_done && ch_en && !clamp_mode) |=> (out_en && ovl_flag));

  p_retry_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RETRY && interval_done && ch_en && !clamp_mode && ovl) |=> (!out_en && ovl_flag));

  p_clamp_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN && ch_en && clamp_mode) |=> (out_en && (ovl_flag == $past(ovl))));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_OFF || st_q == S_RETRY) && ch_en && clamp_mode) |=> out_en);

endmodule

// File: rtl/olp_guard.sv
module olp_guard #(
  parameter int T_OFF_MS = 900,
  parameter int T_ON_MS  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ch_en,
  input  logic clamp_mode,
  input  logic hi_limit,
  input  logic ss_done,
  input  logic ms_tick,
  input  logic ovl,
  output logic out_en,
  output logic lim_hi,
  output logic ovl_flag
);
  import olp_pkg::*;

  olp_state_e st;
  logic       state_change;
  logic       interval_done;
  logic       timing;

  assign timing = (st == S_OFF) || (st == S_RETRY);

  olp_interval_timer #(.T_OFF_MS(T_OFF_MS), .T_ON_MS(T_ON_MS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (timing),
    .sel_off (st == S_OFF),
    .clr     (state_change),
    .tick    (ms_tick),
    .expired (interval_done)
  );

  olp_hiccup_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .ch_en         (ch_en),
    .clamp_mode    (clamp_mode),
    .ss_done       (ss_done),
    .ovl           (ovl),
    .interval_done (interval_done),
    .st_q          (st),
    .state_change  (state_change),
    .out_en        (out_en),
    .ovl_flag      (ovl_flag)
  );

  assign lim_hi = hi_limit;

  p_limit_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RETRY) |-> (lim_hi == hi_limit));

endmodule

// File: tb/tb_olp_guard.sv
module tb_olp_guard;

  localparam int TOFF = 5;
  localparam int TON  = 3;
  localparam int NSTEP = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ch_en = 1'b0, clamp_mode = 1'b0, hi_limit = 1'b0;
  logic ss_done = 1'b0, ms_tick = 1'b0, ovl = 1'b0;
  logic out_en, lim_hi, ovl_flag;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  olp_guard #(.T_OFF_MS(TOFF), .T_ON_MS(TON)) dut (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .clamp_mode(clamp_mode),
    .hi_limit(hi_limit), .ss_done(ss_done), .ms_tick(ms_tick), .ovl(ovl),
    .out_en(out_en), .lim_hi(lim_hi), .ovl_flag(ovl_flag)
  );

  // {en, ss, clamp, hi, ovl, ticks[3:0], exp_out, exp_flag}
  localparam logic [10:0] VEC [NSTEP] = '{
    {5'b10000, 4'd0,  2'b10},  //  0 R3 soft start
    {5'b10001, 4'd0,  2'b10},  //  1 R3 overload ignored in soft start
    {5'b11000, 4'd0,  2'b10},  //  2 R3 soft start done -> run
    {5'b11001, 4'd0,  2'b01},  //  3 R4 trip
    {5'b11000, 4'd4,  2'b01},  //  4 R5 one tick short
    {5'b11010, 4'd1,  2'b11},  //  5 R5/R10 retry, high limit
    {5'b11011, 4'd1,  2'b11},  //  6 R6 overload inside retry
    {5'b11000, 4'd2,  2'b01},  //  7 R6 failed retry -> off
    {5'b11000, 4'd5,  2'b11},  //  8 R5 second retry
    {5'b11000, 4'd3,  2'b10},  //  9 R7 clean retry -> run
    {5'b11101, 4'd0,  2'b11},  // 10 R8 clamp flag up
    {5'b11101, 4'd10, 2'b11},  // 11 R8 output stays on
    {5'b11100, 4'd0,  2'b10},  // 12 R8 flag clears
    {5'b11001, 4'd0,  2'b01},  // 13 R4 trip again
    {5'b11101, 4'd0,  2'b11},  // 14 R9 abort to clamp
    {5'b11100, 4'd0,  2'b10},  // 15 R9 flag follows ovl
    {5'b01000, 4'd0,  2'b00},  // 16 R2 disable
    {5'b11000, 4'd0,  2'b10},  // 17 R2 re-enable straight to run
    {5'b11011, 4'd0,  2'b01},  // 18 R4 trip
    {5'b01001, 4'd2,  2'b00}   // 19 R2 disable mid-cycle
  };

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_en at reset", out_en, 1'b0);
    check("R1 ovl_flag at reset", ovl_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_en after reset", out_en, 1'b0);

    for (int i = 0; i < NSTEP; i++) begin
      logic [10:0] v;
      v = VEC[i];
      ch_en = v[10]; ss_done = v[9]; clamp_mode = v[8];
      hi_limit = v[7]; ovl = v[6];
      pulse_ticks(int'(v[5:2]));
      @(negedge clk);
      check($sformatf("step %0d out_en", i), out_en, v[1]);
      check($sformatf("step %0d ovl_flag", i), ovl_flag, v[0]);
      check($sformatf("R10 step %0d lim_hi", i), lim_hi, v[7]);
    end

    // R5 directed: tick count that ends off interval lands exactly on expiry
    ch_en = 1'b1; ss_done = 1'b1; clamp_mode = 1'b0; ovl = 1'b0;
    @(negedge clk);
    ovl = 1'b1; @(negedge clk); ovl = 1'b0;
    check("R4 directed trip", out_en, 1'b0);
    pulse_ticks(TOFF - 1);
    check("R5 still off before last tick", out_en, 1'b0);
    pulse_ticks(1);
    check("R5 on after last tick", out_en, 1'b1);
    check("R5 flag held in retry", ovl_flag, 1'b1);
    pulse_ticks(TON - 1);
    check("R7 retry not yet over", ovl_flag, 1'b1);
    pulse_ticks(1);
    check("R7 clean retry clears flag", ovl_flag, 1'b0);
    check("R7 output on", out_en, 1'b1);

    // R8 latency: flag follows ovl one clock later
    clamp_mode = 1'b1; ovl = 1'b1;
    @(negedge clk);
    check("R8 flag after one clock", ovl_flag, 1'b1);
    ovl = 1'b0;
    @(negedge clk);
    check("R8 flag drops", ovl_flag, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule